// File: doc/BRIEF.md
# MDIO Management Register Controller

This block gives a processor a small register pair for reaching the management registers of an external Ethernet PHY over the two-wire MDC/MDIO interface. Software programs a command register with these fields:

- the target PHY address;
- the target register address;
- a direction flag;
- a divider selection for the management clock;
- a busy/go bit.

Setting the busy/go bit launches one management frame. The same bit reads back as set for as long as the frame is on the wire, so software polls it to learn when the frame is done.

For a write transaction, software first loads the 16-bit data register. The block then sends, MSB first, the following sequence:

- a 32-bit preamble of ones;
- the start pattern;
- the opcode;
- both addresses;
- the turnaround;
- the data.

For a read transaction, the block releases MDIO from the turnaround onward. It captures the 16 bits the PHY returns and places them in the data register when the frame completes. MDC is produced by dividing the system clock with a divider picked by the clock-range field. MDC is held low between frames.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, both registers read zero, MDC is low, MDIO output enable is high and MDIO output is 1.
- R2: Writing the command register with bit 0 (busy/go) set starts a frame, and bit 0 reads 1 until the frame ends. Writing it with bit 0 clear only stores the fields and starts nothing.
- R3: The command register layout is as follows:
  - bit 1 is the direction flag;
  - bits 4:2 are the clock-range selector;
  - bits 9:5 are the register address;
  - bits 14:10 are the PHY address.
  - A direction flag of 1 sends opcode 01 (write) and a flag of 0 sends opcode 10 (read).
- R4: Each frame is 64 MDC periods, all fields MSB first, in this order:
  - 32 ones;
  - start bits 0 then 1;
  - the 2-bit opcode;
  - the 5-bit PHY address;
  - the 5-bit register address;
  - 2 turnaround bits;
  - 16 data bits.
  - For a write, the turnaround bits are 1 then 0.
- R5: The clock-range selector sets the MDC period, with MDC high and low for equal halves:
  - selector 0 gives a period of 62 system clocks;
  - selector s of 1 to 7 gives a period of 4*(s+1) system clocks.
- R6: Write data comes from the 16-bit data register. It is frozen at the start of the frame.
- R7: On a read, MDIO output enable is low exactly for the two turnaround bits and the 16 data bits. MDIO input is sampled on each rising MDC edge of the data bits, and the word appears in the data register when busy clears. On a write, output enable stays high throughout.
- R8: During a frame, MDIO output changes only at a falling edge of MDC.
- R9: Writes to the command register while busy is set are ignored.
- R10: At completion only the busy bit clears. The direction, clock-range and address fields read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 15 | Command register write value |
| cmd_rdata | output | 15 | Command register read value, busy in bit 0 |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Data register write value |
| data_rdata | output | 16 | Data register read value (read result after a read) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high drives the line |
| mdio_i | input | 1 | MDIO input value from the line |

## Verification
The hardest case to reach from the ports is a command write that lands in the middle of a running frame. It must disturb neither the bits still to be sent nor the fields read back afterwards. The stimulus starts a frame and lets the scoreboard queue hold the full expected bit sequence. Part-way through the preamble, it issues conflicting command writes, one with the go bit set and one with it clear. Every remaining MDC bit is then compared against the queue, and the command register is compared with its pre-intrusion value once busy drops. Read frames are driven by a PHY model that changes MDIO input only after MDC falls. This shows the capture happens on the rising edge and that the word lands in the data register when busy clears.

// File: rtl/mdio_pkg.sv
// Shared constants for the MDIO management controller.
// Assumes a 15-bit command register and a 64-bit management frame.
package mdio_pkg;
    localparam int CMD_W    = 15;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int CR_W     = 3;
    localparam int HALF_W   = 6;
    localparam int FRAME_LEN = 64;
    localparam int IDX_W    = $clog2(FRAME_LEN);
    localparam int TA_POS   = 46;
    localparam int DATA_POS = 48;

    // Field positions inside the command register
    localparam int BUSY_BIT = 0;
    localparam int DIR_BIT  = 1;
    localparam int CR_LSB   = 2;
    localparam int RA_LSB   = CR_LSB + CR_W;
    localparam int PA_LSB   = RA_LSB + ADDR_W;

    // Half period minus one, in system clocks, for a clock-range selector
    function automatic logic [HALF_W-1:0] mdc_half_m1(input logic [CR_W-1:0] sel);
        if (sel == '0) return HALF_W'(30);
        return HALF_W'(2 * int'(sel) + 1);
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: divides the system clock by an even ratio while enabled.
// Assumes half_m1 is stable whenever en is high. MDC rests low when disabled.
module mdio_clkgen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] half_m1,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    // Terminal count of the current half period
    always_comb begin
        wrap      = en && (cnt == half_m1);
        rise_tick = wrap && !mdc;
        fall_tick = wrap && mdc;
    end

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);
    // R5
    mdc_toggle_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(en));
endmodule

// File: rtl/mdio_shifter.sv
// Frame engine: loads a full management frame on start, shifts it out on
// MDC falling ticks, captures read data on MDC rising ticks. Assumes the
// tick inputs come from the MDC generator enabled by 'active'.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);
    logic [FRAME_LEN-1:0] sr;
    logic [IDX_W-1:0]     bitidx;
    logic                 rd_q;
    logic [FRAME_LEN-1:0] frame;

    // Assemble the frame to be sent
    always_comb begin
        frame = {{32{1'b1}}, 2'b01, (is_wr ? 2'b01 : 2'b10), phy_addr, reg_addr,
                 (is_wr ? 2'b10 : 2'b11), (is_wr ? wdata : {DATA_W{1'b0}})};
    end

    // Line drivers: idle high, released during read turnaround and data
    always_comb begin
        mdio_o  = active ? sr[FRAME_LEN-1] : 1'b1;
        mdio_oe = !(active && rd_q && (bitidx >= IDX_W'(TA_POS)));
    end

    // Frame sequencing, shifting and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '1;
            bitidx <= '0;
            rd_q   <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                sr     <= frame;
                bitidx <= '0;
                rd_q   <= !is_wr;
                active <= 1'b1;
                rdata  <= '0;
            end else if (active) begin
                if (rise_tick && rd_q && (bitidx >= IDX_W'(DATA_POS)))
                    rdata <= {rdata[DATA_W-2:0], mdio_i};
                if (fall_tick) begin
                    if (bitidx == IDX_W'(FRAME_LEN-1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        sr     <= '1;
                    end else begin
                        bitidx <= bitidx + 1'b1;
                        sr     <= {sr[FRAME_LEN-2:0], 1'b1};
                    end
                end
            end
        end
    end

    // R8
    shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && $past(active) && !$stable(sr) |-> $past(fall_tick));
    // R7
    write_keeps_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && !rd_q |-> mdio_oe);
    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active && $past(active));
endmodule

// File: rtl/mdio_cmd_regs.sv
// Command and data registers. The busy bit is both the go trigger and the
// completion flag. Assumes done is a one-cycle pulse from the frame engine.
module mdio_cmd_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rdata,
    output logic              start,
    output logic              is_wr,
    output logic [CR_W-1:0]   cr_sel,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] data_q,
    output logic [CMD_W-1:0]  cmd_rdata
);
    logic busy;

    // Command register readback
    always_comb cmd_rdata = {phy_addr, reg_addr, cr_sel, is_wr, busy};

    // Command fields, busy flag and start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            start    <= 1'b0;
            is_wr    <= 1'b0;
            cr_sel   <= '0;
            phy_addr <= '0;
            reg_addr <= '0;
        end else begin
            start <= 1'b0;
            if (done) begin
                busy <= 1'b0;
            end else if (cmd_wr && !busy) begin
                busy     <= cmd_wdata[BUSY_BIT];
                start    <= cmd_wdata[BUSY_BIT];
                is_wr    <= cmd_wdata[DIR_BIT];
                cr_sel   <= cmd_wdata[CR_LSB +: CR_W];
                reg_addr <= cmd_wdata[RA_LSB +: ADDR_W];
                phy_addr <= cmd_wdata[PA_LSB +: ADDR_W];
            end
        end
    end

    // Data register: software writes, read result at completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (done && !is_wr)
            data_q <= rdata;
        else if (data_wr)
            data_q <= data_wdata;
    end

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable({phy_addr, reg_addr, cr_sel, is_wr}));
    // R2
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// MDIO management controller top: register pair, MDC generator and frame
// engine. Assumes a single system clock and synchronous active-low reset.
module mdio_mgmt_ctrl
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              start, is_wr, active, done, rise_tick, fall_tick;
    logic [CR_W-1:0]   cr_sel;
    logic [ADDR_W-1:0] phy_addr, reg_addr;
    logic [DATA_W-1:0] rdata;
    logic [HALF_W-1:0] half_m1;

    // Divider selection from the clock-range field
    always_comb half_m1 = mdc_half_m1(cr_sel);

    mdio_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .done(done), .rdata(rdata),
        .start(start), .is_wr(is_wr), .cr_sel(cr_sel), .phy_addr(phy_addr),
        .reg_addr(reg_addr), .data_q(data_rdata), .cmd_rdata(cmd_rdata)
    );

    mdio_clkgen #(.CNT_W(HALF_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(active), .half_m1(half_m1),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .is_wr(is_wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(data_rdata),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .active(active), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rdata(rdata)
    );
endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [14:0] cmd_wdata = '0;
    logic [14:0] cmd_rdata;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [15:0] data_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    typedef struct packed { logic oe; logic b; } item_t;
    item_t exp_q[$];
    int compared = 0;
    int mismatched = 0;
    int bitpos = 0;
    logic [15:0] rd_val = '0;
    int edge_viol = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: one expected item per rising MDC edge (R4, R6, R7)
    always @(posedge mdc) begin
        #1;
        if (exp_q.size() == 0) begin
            chk(0, "R4 unexpected MDC bit", bitpos, -1);
        end else begin
            item_t it;
            it = exp_q.pop_front();
            chk(mdio_oe == it.oe, "R7 oe", int'(mdio_oe), int'(it.oe));
            if (it.oe) chk(mdio_o == it.b, "R4/R6 frame bit", int'(mdio_o), int'(it.b));
        end
        bitpos++;
    end

    // PHY model: present read data after MDC falls
    always @(negedge mdc) begin
        #1;
        mdio_i = (bitpos >= 48 && bitpos < 64) ? rd_val[63 - bitpos] : 1'b1;
    end

    // R8 watcher: MDIO output may change only together with a falling MDC
    logic prev_o = 1'b1, prev_mdc = 1'b0, prev_busy = 1'b0;
    always @(negedge clk) begin
        if (prev_busy && cmd_rdata[0] && (mdio_o != prev_o) && !(prev_mdc && !mdc))
            edge_viol++;
        prev_o = mdio_o; prev_mdc = mdc; prev_busy = cmd_rdata[0];
    end

    task automatic cmd_write(input logic [14:0] v);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    function automatic int exp_period(input logic [2:0] s);
        return (s == 0) ? 62 : 4 * (int'(s) + 1);
    endfunction

    // Driver: push expected frame and launch it
    task automatic start_op(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [2:0] cr, input logic [15:0] wd, input logic [15:0] rv);
        @(negedge clk); data_wr = 1'b1; data_wdata = wd;
        @(negedge clk); data_wr = 1'b0;
        rd_val = rv; bitpos = 0;
        for (int i = 0; i < 64; i++) begin
            item_t it;
            it.oe = 1'b1; it.b = 1'b1;
            if (i == 32) it.b = 1'b0;
            else if (i == 34) it.b = wr ? 1'b0 : 1'b1;
            else if (i == 35) it.b = wr ? 1'b1 : 1'b0;
            else if (i >= 36 && i <= 40) it.b = pa[40 - i];
            else if (i >= 41 && i <= 45) it.b = ra[45 - i];
            else if (i >= 46) begin
                if (!wr) it.oe = 1'b0;
                else if (i == 46) it.b = 1'b1;
                else if (i == 47) it.b = 1'b0;
                else it.b = wd[63 - i];
            end
            exp_q.push_back(it);
        end
        cmd_write({pa, ra, cr, wr, 1'b1});
        chk(cmd_rdata[0] == 1'b1, "R2 busy set after go", int'(cmd_rdata[0]), 1);
    endtask

    task automatic finish_op(input logic [14:0] cmdv, input bit wr, input logic [15:0] rv);
        int n = 0;
        while (cmd_rdata[0] && n < 20000) begin @(negedge clk); n++; end
        chk(n < 20000, "R2 busy clears", n, 20000);
        chk(exp_q.size() == 0, "R4 all 64 bits sent", exp_q.size(), 0);
        exp_q.delete();
        chk(cmd_rdata == {cmdv[14:1], 1'b0}, "R10 fields kept", int'(cmd_rdata), int'({cmdv[14:1], 1'b0}));
        if (!wr) chk(data_rdata == rv, "R7 read data", int'(data_rdata), int'(rv));
        chk(edge_viol == 0, "R8 mdio changes on MDC fall", edge_viol, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b1, "R1 idle line", int'({mdc, mdio_oe}), 1);
    endtask

    task automatic measure(input logic [2:0] cr);
        time t1, t2, t3;
        @(posedge mdc); t1 = $time;
        @(negedge mdc); t2 = $time;
        @(posedge mdc); t3 = $time;
        chk((t2 - t1) / 4 == exp_period(cr) / 2, "R5 high half", int'((t2 - t1) / 4), exp_period(cr) / 2);
        chk((t3 - t2) / 4 == exp_period(cr) / 2, "R5 low half", int'((t3 - t2) / 4), exp_period(cr) / 2);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_rdata == 0 && data_rdata == 0, "R1 regs zero", int'(cmd_rdata), 0);
        chk(mdc == 0 && mdio_oe == 1 && mdio_o == 1, "R1 line idle", int'({mdc, mdio_oe, mdio_o}), 3);

        // R2 store without go
        cmd_write({5'd3, 5'd7, 3'd2, 1'b1, 1'b0});
        repeat (40) @(negedge clk);
        chk(mdc == 0 && cmd_rdata == {5'd3, 5'd7, 3'd2, 1'b1, 1'b0}, "R2 no start", int'(cmd_rdata), int'({5'd3, 5'd7, 3'd2, 1'b1, 1'b0}));

        // R3 R6 write frame, selector 1, with period check
        start_op(1'b1, 5'h11, 5'h0A, 3'd1, 16'hA5C3, 16'h0);
        measure(3'd1);
        finish_op({5'h11, 5'h0A, 3'd1, 1'b1, 1'b1}, 1'b1, 16'h0);

        // R3 R7 read frame, selector 3
        start_op(1'b0, 5'h1F, 5'h01, 3'd3, 16'h0000, 16'h96E1);
        measure(3'd3);
        finish_op({5'h1F, 5'h01, 3'd3, 1'b0, 1'b1}, 1'b0, 16'h96E1);

        // R9 intrusion during a write frame
        start_op(1'b1, 5'h05, 5'h1C, 3'd2, 16'h7F01, 16'h0);
        repeat (30) @(negedge clk);
        cmd_write({5'h1A, 5'h02, 3'd7, 1'b0, 1'b1});
        cmd_write({5'h00, 5'h00, 3'd0, 1'b0, 1'b0});
        chk(cmd_rdata == {5'h05, 5'h1C, 3'd2, 1'b1, 1'b1}, "R9 ignored while busy", int'(cmd_rdata), int'({5'h05, 5'h1C, 3'd2, 1'b1, 1'b1}));
        finish_op({5'h05, 5'h1C, 3'd2, 1'b1, 1'b1}, 1'b1, 16'h0);

        // R5 selector 0 gives divide by 62, read of all-ones
        start_op(1'b0, 5'h00, 5'h1F, 3'd0, 16'h1234, 16'hFFFF);
        measure(3'd0);
        finish_op({5'h00, 5'h1F, 3'd0, 1'b0, 1'b1}, 1'b0, 16'hFFFF);

        // R7 read of alternating pattern, selector 7
        start_op(1'b0, 5'h0C, 5'h13, 3'd7, 16'hFFFF, 16'h5AA5);
        finish_op({5'h0C, 5'h13, 3'd7, 1'b0, 1'b1}, 1'b0, 16'h5AA5);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule